// File: doc/BRIEF.md
# Channel averaging and window alarm

This block sits behind the conversion sequencer of an on-chip monitor. Each cycle it may receive one conversion result together with the number of the channel it belongs to. A channel can have averaging turned on through a per-channel bitmap. A two-bit mode field sets a shared sample count for all such channels. An averaged channel collects that many results and then publishes their mean. A channel without averaging passes every sample straight to the output. The published measurement is registered and comes out with a one-cycle valid strobe and its channel number.

A small set of alarm outputs watches fixed channels, and each alarm has its own lower and upper limit. A published measurement for a watched channel sets the alarm when it lies strictly outside the window. The alarm clears when a later measurement lies inside. Every alarm has its own disable bit that holds it low. The register bus and the converter stay outside the block. Configuration arrives as plain input words.

Top module: `chan_avg_alarm`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `res_valid` is 0 and every `alarm` bit is 0.
- R2: A sample on a channel whose `avg_en` bit is 0 appears on `res_data`/`res_chan` with `res_valid` high in the cycle after `smp_valid`.
- R3: With `avg_mode` = 2'b00, every channel passes samples through as in R2, whatever its `avg_en` bit.
- R4: With `avg_en[ch]` set, `avg_mode` 2'b01, 2'b10 and 2'b11 average 16, 64 and 256 samples. No result appears for the earlier samples. The N-th sample yields `res_valid` with the sum divided by N, rounded down, including full-scale 16'hFFFF inputs.
- R5: After publishing an average, the channel starts a fresh sum, so the next result covers only the next N samples.
- R6: Averaged channels keep separate sums when their samples interleave.
- R7: A change of `avg_mode` clears every partial sum. A change of a channel's `avg_en` bit clears that channel's partial sum. The next result then covers N samples taken after the change.
- R8: In the cycle after a published measurement on its channel, an alarm goes high if the value is above `lim_hi` or below `lim_lo`. A value equal to a limit counts as inside. Averaged channels update the alarm only from the published average.
- R9: An alarm returns low after a published measurement back inside its window.
- R10: While `alm_dis[i]` is 1, `alarm[i]` is 0 from the next cycle on. Its state is cleared, so after re-enabling it stays 0 until a new measurement on its channel.
- R11: An alarm keeps its value while no measurement is published on its own channel. Measurements on other channels do not change it.
- R12: Alarm i watches channel `ALM_CH[i*CHAN_W +: CHAN_W]`, with limits in slice i of `lim_hi`/`lim_lo`. The default map is alarm 0 on channel 1, alarm 1 on channel 2 and alarm 2 on channel 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Conversion result strobe |
| smp_chan | input | CHAN_W | Channel number of the result |
| smp_data | input | DATA_W | Conversion result |
| avg_mode | input | 2 | Sample count: 00 off, 01 16, 10 64, 11 256 |
| avg_en | input | 2**CHAN_W | Per-channel averaging enable |
| alm_dis | input | N_ALM | Per-alarm disable, 1 = disabled |
| lim_hi | input | N_ALM*DATA_W | Upper limit per alarm |
| lim_lo | input | N_ALM*DATA_W | Lower limit per alarm |
| res_valid | output | 1 | Measurement strobe |
| res_chan | output | CHAN_W | Channel of the measurement |
| res_data | output | DATA_W | Measurement value |
| alarm | output | N_ALM | Window alarm per watched channel |

## Verification
The hardest case to reach from the ports is a configuration change that lands while a channel holds a partial sum. If the restart were missing, the next result would arrive early and carry stale samples. The bench loads a few full-scale samples and flips the enable bit, or the mode, off and back for a single cycle. It then sends a distinct pattern and checks that the result arrives on exactly the N-th later sample with that pattern's mean. Alarm hold and clearing are shown the same way: one alarm is set high, and then a dense sweep runs on another watched channel.

// File: rtl/chan_avg_alarm_pkg.sv
package chan_avg_alarm_pkg;

  typedef enum logic [1:0] {
    AVG_OFF = 2'b00,
    AVG_16  = 2'b01,
    AVG_64  = 2'b10,
    AVG_256 = 2'b11
  } avg_mode_e;

  // log2 of the sample count for each mode
  function automatic logic [3:0] avg_shift(input avg_mode_e m);
    case (m)
      AVG_16:  avg_shift = 4'd4;
      AVG_64:  avg_shift = 4'd6;
      AVG_256: avg_shift = 4'd8;
      default: avg_shift = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/avgm_accum.sv
module avgm_accum
  import chan_avg_alarm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [CHAN_W-1:0]        in_chan,
  input  logic [DATA_W-1:0]        in_data,
  input  logic [1:0]               avg_mode,
  input  logic [(1<<CHAN_W)-1:0]   avg_en,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data
);

  localparam int NUM_CH = 1 << CHAN_W;
  localparam int ACC_W  = DATA_W + 8;
  localparam int CNT_W  = 9;

  logic [ACC_W-1:0]  acc_q [NUM_CH];
  logic [ACC_W-1:0]  acc_d [NUM_CH];
  logic [CNT_W-1:0]  cnt_q [NUM_CH];
  logic [CNT_W-1:0]  cnt_d [NUM_CH];
  logic [1:0]        mode_q;
  logic [NUM_CH-1:0] en_q;

  avg_mode_e         mode;
  logic [3:0]        shamt;
  logic [CNT_W-1:0]  limit;
  logic              mode_chg;
  logic [NUM_CH-1:0] restart;
  logic              avg_on;
  logic [ACC_W-1:0]  base_acc;
  logic [CNT_W-1:0]  base_cnt;
  logic [ACC_W-1:0]  sum;
  logic [CNT_W-1:0]  cnt_inc;
  logic              done;
  logic              state_we;

  assign mode     = avg_mode_e'(avg_mode);
  assign shamt    = avg_shift(mode);
  assign limit    = CNT_W'(1) << shamt;
  assign mode_chg = (avg_mode != mode_q);
  assign restart  = {NUM_CH{mode_chg}} | (avg_en ^ en_q);
  assign avg_on   = (mode != AVG_OFF) && avg_en[in_chan];

  assign base_acc = restart[in_chan] ? '0 : acc_q[in_chan];
  assign base_cnt = restart[in_chan] ? '0 : cnt_q[in_chan];
  assign sum      = base_acc + ACC_W'(in_data);
  assign cnt_inc  = base_cnt + CNT_W'(1);
  assign done     = (cnt_inc == limit);

  assign out_valid = in_valid && (!avg_on || done);
  assign out_data  = avg_on ? DATA_W'(sum >> shamt) : in_data;
  assign state_we  = (in_valid && avg_on) || (|restart);

  // next state of the per-channel sums
  always_comb begin
    acc_d = acc_q;
    cnt_d = cnt_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (restart[c]) begin
        acc_d[c] = '0;
        cnt_d[c] = '0;
      end
    end
    if (in_valid && avg_on) begin
      acc_d[in_chan] = done ? '0 : sum;
      cnt_d[in_chan] = done ? '0 : cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
      for (int c = 0; c < NUM_CH; c++) begin
        acc_q[c] <= '0;
        cnt_q[c] <= '0;
      end
    end else begin
      mode_q <= avg_mode;
      en_q   <= avg_en;
      if (state_we) begin
        acc_q <= acc_d;
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/avgm_window.sv
module avgm_window #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4,
  parameter int N_ALM  = 3,
  parameter logic [N_ALM*CHAN_W-1:0] ALM_CH = 12'hA21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  input  logic [CHAN_W-1:0]       s_chan,
  input  logic [DATA_W-1:0]       s_data,
  input  logic [N_ALM*DATA_W-1:0] lim_hi,
  input  logic [N_ALM*DATA_W-1:0] lim_lo,
  input  logic [N_ALM-1:0]        alm_dis,
  output logic [N_ALM-1:0]        alarm_o
);

  logic [N_ALM-1:0] hit;
  logic [N_ALM-1:0] outside;
  logic [N_ALM-1:0] alm_d;
  logic [N_ALM-1:0] alm_we;
  logic [N_ALM-1:0] alm_q;

  for (genvar i = 0; i < N_ALM; i++) begin : g_alm
    assign hit[i]     = s_valid && (s_chan == ALM_CH[i*CHAN_W +: CHAN_W]);
    assign outside[i] = (s_data > lim_hi[i*DATA_W +: DATA_W]) ||
                        (s_data < lim_lo[i*DATA_W +: DATA_W]);
    assign alm_d[i]   = alm_dis[i] ? 1'b0 : outside[i];
    assign alm_we[i]  = alm_dis[i] || hit[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
    end else begin
      for (int i = 0; i < N_ALM; i++) begin
        if (alm_we[i]) alm_q[i] <= alm_d[i];
      end
    end
  end

  assign alarm_o = alm_q;

endmodule

// File: rtl/chan_avg_alarm.sv
module chan_avg_alarm #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4,
  parameter int N_ALM  = 3,
  parameter logic [N_ALM*CHAN_W-1:0] ALM_CH = 12'hA21
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [CHAN_W-1:0]       smp_chan,
  input  logic [DATA_W-1:0]       smp_data,
  input  logic [1:0]              avg_mode,
  input  logic [(1<<CHAN_W)-1:0]  avg_en,
  input  logic [N_ALM-1:0]        alm_dis,
  input  logic [N_ALM*DATA_W-1:0] lim_hi,
  input  logic [N_ALM*DATA_W-1:0] lim_lo,
  output logic                    res_valid,
  output logic [CHAN_W-1:0]       res_chan,
  output logic [DATA_W-1:0]       res_data,
  output logic [N_ALM-1:0]        alarm
);

  logic              rst_meta_n;
  logic              rst_sync_n;
  logic              av_valid;
  logic [DATA_W-1:0] av_data;
  logic              res_valid_q;
  logic [CHAN_W-1:0] res_chan_q;
  logic [DATA_W-1:0] res_data_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  avgm_accum #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_accum (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .in_valid (smp_valid),
    .in_chan  (smp_chan),
    .in_data  (smp_data),
    .avg_mode (avg_mode),
    .avg_en   (avg_en),
    .out_valid(av_valid),
    .out_data (av_data)
  );

  avgm_window #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .N_ALM(N_ALM), .ALM_CH(ALM_CH)) u_window (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .s_valid (av_valid),
    .s_chan  (smp_chan),
    .s_data  (av_data),
    .lim_hi  (lim_hi),
    .lim_lo  (lim_lo),
    .alm_dis (alm_dis),
    .alarm_o (alarm)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid_q <= 1'b0;
      res_chan_q  <= '0;
      res_data_q  <= '0;
    end else begin
      res_valid_q <= av_valid;
      if (av_valid) begin
        res_chan_q <= smp_chan;
        res_data_q <= av_data;
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_chan  = res_chan_q;
  assign res_data  = res_data_q;

endmodule

// File: rtl/chan_avg_alarm_chk.sv
module chan_avg_alarm_chk #(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 4,
  parameter int N_ALM  = 3,
  parameter logic [N_ALM*CHAN_W-1:0] ALM_CH = 12'hA21
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_valid,
  input logic [CHAN_W-1:0]      smp_chan,
  input logic [DATA_W-1:0]      smp_data,
  input logic [1:0]             avg_mode,
  input logic [(1<<CHAN_W)-1:0] avg_en,
  input logic [N_ALM-1:0]       alm_dis,
  input logic                   res_valid,
  input logic [CHAN_W-1:0]      res_chan,
  input logic [DATA_W-1:0]      res_data,
  input logic [N_ALM-1:0]       alarm
);

  // R2, R3: unaveraged samples reach the output one cycle later
  p_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && (avg_mode == 2'b00 || !avg_en[smp_chan]) |=>
      res_valid && res_data == $past(smp_data) && res_chan == $past(smp_chan));

  // R4: a result strobe always follows an input sample
  p_valid_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(smp_valid));

  for (genvar i = 0; i < N_ALM; i++) begin : g_chk
    // R10: a disabled alarm is low on the next cycle
    p_dis_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      alm_dis[i] |=> !alarm[i]);

    // R11: without a sample on its channel the alarm holds
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !alm_dis[i] && !(smp_valid && smp_chan == ALM_CH[i*CHAN_W +: CHAN_W]) |=>
        alarm[i] == $past(alarm[i]));

    // R8: an alarm only rises after a sample on its own channel
    p_rise_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm[i]) |-> $past(smp_valid) && $past(smp_chan) == ALM_CH[i*CHAN_W +: CHAN_W]);
  end

endmodule

bind chan_avg_alarm chan_avg_alarm_chk #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .N_ALM(N_ALM), .ALM_CH(ALM_CH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .smp_valid(smp_valid),
  .smp_chan (smp_chan),
  .smp_data (smp_data),
  .avg_mode (avg_mode),
  .avg_en   (avg_en),
  .alm_dis  (alm_dis),
  .res_valid(res_valid),
  .res_chan (res_chan),
  .res_data (res_data),
  .alarm    (alarm)
);

// File: tb/chan_avg_alarm_test.sv
module chan_avg_alarm_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        smp_valid;
  logic [3:0]  smp_chan;
  logic [15:0] smp_data;
  logic [1:0]  avg_mode;
  logic [15:0] avg_en;
  logic [2:0]  alm_dis;
  logic [47:0] lim_hi;
  logic [47:0] lim_lo;
  logic        res_valid;
  logic [3:0]  res_chan;
  logic [15:0] res_data;
  logic [2:0]  alarm;

  int checks;
  int fails;
  logic        got_v;
  logic [15:0] got_d;
  logic [3:0]  got_c;
  logic [2:0]  got_a;

  chan_avg_alarm uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .avg_mode(avg_mode), .avg_en(avg_en), .alm_dis(alm_dis),
    .lim_hi(lim_hi), .lim_lo(lim_lo), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .alarm(alarm)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sample in, outputs captured one cycle later
  task automatic send(input logic [3:0] ch, input logic [15:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk);
    got_v = res_valid; got_d = res_data; got_c = res_chan; got_a = alarm;
    smp_valid = 1'b0;
  endtask

  function automatic logic [15:0] pat(input int seed, input int k);
    return 16'((seed * 7919 + k * 40503) & 16'hFFFF);
  endfunction

  // N samples on a channel; result must appear on the last one only
  task automatic avg_run(input logic [3:0] ch, input int n, input int seed, input string req);
    int sum = 0;
    int early = 0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] d = (seed < 0) ? 16'hFFFF : pat(seed, k);
      sum += int'(d);
      send(ch, d);
      if (k < n - 1 && got_v) early++;
    end
    check(early == 0, {req, " no early result"}, early, 0);
    check(got_v && got_d == 16'(sum / n) && got_c == ch, {req, " average"}, int'(got_d), sum / n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    checks = 0; fails = 0;
    rst_n = 1'b0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
    avg_mode = 2'b00; avg_en = '0; alm_dis = '0;
    lim_hi = {16'hA800, 16'hFFFF, 16'hC000};
    lim_lo = {16'h9800, 16'h0000, 16'h4000};

    // R1
    idle(3);
    check(res_valid == 1'b0 && alarm == 3'b000, "R1 in reset", {res_valid, alarm}, 0);
    rst_n = 1'b1;
    idle(1);
    check(res_valid == 1'b0 && alarm == 3'b000, "R1 after release", {res_valid, alarm}, 0);
    idle(3);

    // R2: every channel, averaging mode set but bitmap clear
    avg_mode = 2'b01;
    begin
      int bad = 0;
      for (int ch = 0; ch < 16; ch++)
        for (int j = 0; j < 4; j++) begin
          logic [15:0] d = 16'(ch * 4099 + j * 16411);
          send(4'(ch), d);
          if (!(got_v && got_d == d && got_c == 4'(ch))) bad++;
        end
      check(bad == 0, "R2 pass-through sweep", bad, 0);
    end

    // R3: mode off overrides an all-ones bitmap
    avg_mode = 2'b00; avg_en = 16'hFFFF;
    begin
      int bad = 0;
      for (int ch = 0; ch < 16; ch++)
        for (int j = 0; j < 2; j++) begin
          logic [15:0] d = 16'(ch * 2311 + j * 30011 + 5);
          send(4'(ch), d);
          if (!(got_v && got_d == d && got_c == 4'(ch))) bad++;
        end
      check(bad == 0, "R3 mode off pass-through", bad, 0);
    end

    // R4, R5: each count, two back-to-back batches on channel 10
    @(negedge clk); avg_en = 16'h0400;
    for (int m = 1; m < 4; m++) begin
      @(negedge clk); avg_mode = 2'(m);
      avg_run(4'd10, 1 << (2 * m + 2), m, "R4");
      avg_run(4'd10, 1 << (2 * m + 2), m + 11, "R5");
    end
    avg_run(4'd10, 256, -1, "R4 full scale");

    // R6: interleaved channels 3 and 10
    @(negedge clk); avg_mode = 2'b01; avg_en = 16'h0408;
    begin
      int sa = 0, sb = 0, early = 0;
      for (int k = 0; k < 16; k++) begin
        send(4'd3, pat(21, k)); sa += int'(pat(21, k));
        if (k < 15 && got_v) early++;
        if (k == 15) check(got_v && got_d == 16'(sa / 16) && got_c == 4'd3, "R6 channel 3", int'(got_d), sa / 16);
        send(4'd10, pat(22, k)); sb += int'(pat(22, k));
        if (k < 15 && got_v) early++;
        if (k == 15) check(got_v && got_d == 16'(sb / 16) && got_c == 4'd10, "R6 channel 10", int'(got_d), sb / 16);
      end
      check(early == 0, "R6 no early result", early, 0);
    end

    // R7: bitmap bit dropped for one cycle mid-batch
    for (int k = 0; k < 5; k++) send(4'd10, 16'hFFFF);
    @(negedge clk); avg_en = 16'h0008;
    @(negedge clk); avg_en = 16'h0408;
    avg_run(4'd10, 16, 31, "R7 enable change");
    // R7: mode changed and restored mid-batch
    for (int k = 0; k < 5; k++) send(4'd10, 16'hFFFF);
    @(negedge clk); avg_mode = 2'b10;
    @(negedge clk); avg_mode = 2'b01;
    avg_run(4'd10, 16, 32, "R7 mode change");

    // R8, R9: window edges on alarm 2 (channel 10), unaveraged
    @(negedge clk); avg_mode = 2'b00; avg_en = 16'h0000;
    send(4'd10, 16'h97FF); check(got_a[2] == 1'b1, "R8 below lower", int'(got_a[2]), 1);
    send(4'd10, 16'h9800); check(got_a[2] == 1'b0, "R9 at lower", int'(got_a[2]), 0);
    send(4'd10, 16'hA800); check(got_a[2] == 1'b0, "R8 at upper", int'(got_a[2]), 0);
    send(4'd10, 16'hA801); check(got_a[2] == 1'b1, "R8 above upper", int'(got_a[2]), 1);
    send(4'd10, 16'hA000); check(got_a[2] == 1'b0, "R9 back inside", int'(got_a[2]), 0);

    // R11, R12: alarm 2 held high during a sweep on channel 1 (alarm 0)
    send(4'd10, 16'hB000);
    begin
      int bad0 = 0, bad2 = 0;
      for (int v = 0; v < 65536; v += 1024) begin
        send(4'd1, 16'(v));
        if (got_a[0] != ((v > 32'hC000) || (v < 32'h4000))) bad0++;
        if (got_a[2] != 1'b1) bad2++;
      end
      foreach (lim_lo[i]) ; // no-op keeps loop style uniform
      check(bad0 == 0, "R12 alarm 0 window sweep on channel 1", bad0, 0);
      check(bad2 == 0, "R11 alarm 2 held during other traffic", bad2, 0);
    end
    send(4'd1, 16'h3FFF);
    @(negedge clk); lim_lo[31:16] = 16'h1000;
    send(4'd2, 16'h0800);
    check(got_a == 3'b111, "R12 alarm 1 on channel 2", int'(got_a), 7);

    // R10: disable clears; re-enable stays low
    @(negedge clk); alm_dis = 3'b100;
    @(negedge clk); check(alarm[2] == 1'b0, "R10 disabled low", int'(alarm[2]), 0);
    send(4'd10, 16'hB000); check(got_a[2] == 1'b0, "R10 disabled ignores sample", int'(got_a[2]), 0);
    @(negedge clk); alm_dis = 3'b000;
    idle(2); check(alarm[2] == 1'b0, "R10 state cleared", int'(alarm[2]), 0);

    // R8: averaged channel only alarms on the published mean
    @(negedge clk); avg_mode = 2'b01; avg_en = 16'h0400;
    begin
      int early = 0;
      for (int k = 0; k < 15; k++) begin
        send(4'd10, 16'hB000);
        if (got_a[2]) early++;
      end
      check(early == 0, "R8 no alarm from partial sum", early, 0);
      send(4'd10, 16'hB000);
      check(got_a[2] == 1'b1 && got_v, "R8 alarm from average", int'(got_a[2]), 1);
    end

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule